// File: doc/BRIEF.md
# Masked Event Interrupt Collector

This block gathers hardware events from a storage controller datapath into one 32-bit interrupt status word. Event sources include a device ready pin, a ready flag decoded from the device status, ECC and CRC error strobes, DMA completion strobes, linear-window disable and suspend strobes, and four live FIFO level flags. Two independent masks govern each bit. The latch mask decides whether a source is recorded at all. The signal mask decides whether a recorded bit drives the single interrupt line.

Because the two masks are separate, software can record an event and poll for it without taking an interrupt. It can also keep an event silent by leaving it out of the latch mask entirely. Sticky event bits are cleared by writing 1 to them. The ready pin is asynchronous, so it is brought into the clock domain through a two-flop stage before its rising edge is detected. A small 32-bit register port with a write strobe and a combinational read gives access to the status word and both masks.

Top module: `evt_irq_top`

## Requirements
- R1: A synchronous active-high reset clears the status word and both masks, and `irq` is low after the reset.
- R2: The status word is at address 0x04, the latch mask at 0x08 and the signal mask at 0x0C. Each mask reads back the full 32-bit value last written to it, and any other address reads 0.
- R3: Bit k of `src_evt` sets a sticky status bit. The mapping is k0 to bit 9 (DMA finished), k1 to bit 10 (streaming DMA), k2 to bit 11 (linear read disabled), k3 to bit 12 (linear write disabled), k4 to bit 16 (CRC error), k5 to bit 17 (ECC error), k6 to bit 24 (linear suspend) and k7 to bit 25 (status ready). The bit is set at the clock edge that samples the source high, and only if the matching latch-mask bit is 1 before that edge.
- R4: A sticky bit stays set until a write to 0x04 carries a 1 in its position. Writing 0 in its position leaves it set.
- R5: When a source event and a write-1-to-clear hit the same bit at the same edge, the bit ends up set.
- R6: Status bit 26 records a rising edge of the asynchronous `rdy_pin`. The pin passes through two synchronizing flops and an edge detector, so the bit is set at the third clock edge after the pin rises. A pin that is held high sets the bit only once.
- R7: Status bits 3 to 0 read `fifo_lvl[3:0]` ANDed with latch-mask bits 3 to 0, as live levels. Writes to these bits have no effect.
- R8: `irq` is high exactly when some bit of (status AND signal mask) is 1. A latched bit whose signal-mask bit is 0 leaves `irq` low.
- R9: Clearing a latch-mask bit does not clear a status bit that is already set.
- R10: Status bits that have no source (31:27, 23:18, 15:13 and 8:4) always read 0, even with every latch bit enabled and every source active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_evt | input | 8 | Event sources, mapped to status bits as in R3 |
| fifo_lvl | input | 4 | Live FIFO level flags for status bits 3..0 |
| rdy_pin | input | 1 | Asynchronous device ready pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the collision of an event with a clear of the same bit. A design that gives priority to the clear would lose the event and read the bit as 0. It counts the exact edge at which a held-high ready pin appears in the status word, and clears that bit while the pin stays high. A design with one flop too few or too many would set the bit an edge early or late, and a level-sensitive design would set it again right after the clear. It also writes ones over the live FIFO bits, disables a latch bit under an already-set status bit, and enables a bit for latching but not for signalling. Wrong masking in these cases shows up as a stale FIFO bit, a lost status bit, or an `irq` raised by a bit that should only be polled.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int NSRC  = 8;
    localparam int NLIVE = 4;

    localparam logic [AW-1:0] OFF_STATUS    = 8'h04;
    localparam logic [AW-1:0] OFF_LATCH_EN  = 8'h08;
    localparam logic [AW-1:0] OFF_SIGNAL_EN = 8'h0C;

    localparam int BIT_RDY_PIN = 26;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_LATCH,
        SEL_SIGNAL
    } reg_sel_e;

    typedef struct packed {
        logic            wen;
        reg_sel_e        sel;
        logic [DW-1:0]   data;
    } bus_op_t;

    // Status bit position of each event source input.
    function automatic int src_bit(input int k);
        case (k)
            0:       return 9;
            1:       return 10;
            2:       return 11;
            3:       return 12;
            4:       return 16;
            5:       return 17;
            6:       return 24;
            default: return 25;
        endcase
    endfunction

    function automatic logic [DW-1:0] spread_src(input logic [NSRC-1:0] s);
        logic [DW-1:0] r;
        r = '0;
        for (int k = 0; k < NSRC; k++) begin
            r[src_bit(k)] = s[k];
        end
        return r;
    endfunction

    localparam logic [DW-1:0] STICKY_MASK =
        spread_src({NSRC{1'b1}}) | (DW'(1) << BIT_RDY_PIN);
    localparam logic [DW-1:0] LIVE_MASK = DW'((1 << NLIVE) - 1);

endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_async,
    output logic pin_rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[i] <= 1'b0;
                    else     chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign pin_rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
    import evt_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_evt,
    input  logic             rdy_rise,
    input  logic [NLIVE-1:0] fifo_lvl,
    input  logic [DW-1:0]    latch_en,
    input  logic [DW-1:0]    clr_vec,
    output logic [DW-1:0]    sts_view
);
    logic [DW-1:0] raw_evt;
    logic [DW-1:0] set_vec;
    logic [DW-1:0] sticky_q;
    logic [DW-1:0] live_vec;

    always_comb begin
        raw_evt              = spread_src(src_evt);
        raw_evt[BIT_RDY_PIN] = rdy_rise;
        set_vec              = raw_evt & latch_en & STICKY_MASK;
    end

    // One flop per bit; a new event outranks a same-edge clear.
    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)             sticky_q[i] <= 1'b0;
                else if (set_vec[i]) sticky_q[i] <= 1'b1;
                else if (clr_vec[i]) sticky_q[i] <= 1'b0;
            end
        end
    endgenerate

    always_comb begin
        live_vec = '0;
        live_vec[NLIVE-1:0] = fifo_lvl & latch_en[NLIVE-1:0];
    end

    assign sts_view = (sticky_q & STICKY_MASK) | live_vec;

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     sts_view,
    output logic [DW-1:0]     latch_en,
    output logic [DW-1:0]     signal_en,
    output logic [DW-1:0]     clr_vec,
    output logic [DW-1:0]     bus_rdata
);
    reg_sel_e sel;
    bus_op_t  op;

    always_comb begin
        if (bus_addr == ADDR_W'(OFF_STATUS))         sel = SEL_STATUS;
        else if (bus_addr == ADDR_W'(OFF_LATCH_EN))  sel = SEL_LATCH;
        else if (bus_addr == ADDR_W'(OFF_SIGNAL_EN)) sel = SEL_SIGNAL;
        else                                         sel = SEL_NONE;
        op.wen  = bus_wen;
        op.sel  = sel;
        op.data = bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_en  <= '0;
            signal_en <= '0;
        end else if (op.wen) begin
            if (op.sel == SEL_LATCH)  latch_en  <= op.data;
            if (op.sel == SEL_SIGNAL) signal_en <= op.data;
        end
    end

    assign clr_vec = (op.wen && op.sel == SEL_STATUS) ? (op.data & STICKY_MASK) : '0;

    always_comb begin
        unique case (op.sel)
            SEL_STATUS: bus_rdata = sts_view;
            SEL_LATCH:  bus_rdata = latch_en;
            SEL_SIGNAL: bus_rdata = signal_en;
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evt_irq_top.sv
module evt_irq_top
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W      = AW,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NSRC-1:0]   src_evt,
    input  logic [NLIVE-1:0]  fifo_lvl,
    input  logic              rdy_pin,
    output logic              irq
);
    logic          rdy_rise;
    logic [DW-1:0] sts_view;
    logic [DW-1:0] latch_en;
    logic [DW-1:0] signal_en;
    logic [DW-1:0] clr_vec;

    evt_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_async (rdy_pin),
        .pin_rise  (rdy_rise)
    );

    evt_irq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .src_evt  (src_evt),
        .rdy_rise (rdy_rise),
        .fifo_lvl (fifo_lvl),
        .latch_en (latch_en),
        .clr_vec  (clr_vec),
        .sts_view (sts_view)
    );

    evt_irq_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sts_view  (sts_view),
        .latch_en  (latch_en),
        .signal_en (signal_en),
        .clr_vec   (clr_vec),
        .bus_rdata (bus_rdata)
    );

    assign irq = |(sts_view & signal_en);

endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = AW
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rdy_pin,
    input logic [DW-1:0]     sts_view,
    input logic [DW-1:0]     latch_en,
    input logic [DW-1:0]     signal_en,
    input logic              irq
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        if (rst_seen_q) begin
            p_rst_clear_r1: assert (sts_view == '0 && latch_en == '0 &&
                                    signal_en == '0 && !irq)
                else $error("reset left state behind");
        end
    end

    p_gate_by_latch_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((sts_view & ~$past(sts_view) & STICKY_MASK & ~$past(latch_en)) == '0));

    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(bus_wen && bus_addr == ADDR_W'(OFF_STATUS)) |=>
            ((sts_view & $past(sts_view) & STICKY_MASK) == ($past(sts_view) & STICKY_MASK)));

    p_ready_synced_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_view[BIT_RDY_PIN]) |-> $past(rdy_pin, 3));

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|(sts_view & signal_en)));

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (signal_en == '0) |-> !irq);

    p_no_phantom_r10: assert property (@(posedge clk) disable iff (rst)
        (sts_view & ~(STICKY_MASK | LIVE_MASK)) == '0);

endmodule

bind evt_irq_top evt_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wen   (bus_wen),
    .bus_addr  (bus_addr),
    .rdy_pin   (rdy_pin),
    .sts_view  (sts_view),
    .latch_en  (latch_en),
    .signal_en (signal_en),
    .irq       (irq)
);

// File: tb/sim_evt_irq_top.sv
module sim_evt_irq_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  src_evt = '0;
    logic [3:0]  fifo_lvl = '0;
    logic        rdy_pin = 1'b0;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_sticky, m_len, m_sen;
    logic        m_p1, m_p2, m_p3;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_irq_top u0 (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
        .fifo_lvl(fifo_lvl), .rdy_pin(rdy_pin), .irq(irq)
    );

    function automatic logic [31:0] place(input logic [7:0] s);
        int pos [8] = '{9, 10, 11, 12, 16, 17, 24, 25};
        logic [31:0] r = '0;
        for (int k = 0; k < 8; k++) r[pos[k]] = s[k];
        return r;
    endfunction

    function automatic logic [31:0] view();
        return m_sticky | {28'b0, fifo_lvl & m_len[3:0]};
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h04:   return view();
            8'h08:   return m_len;
            8'h0C:   return m_sen;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sticky = '0; m_len = '0; m_sen = '0;
        m_p1 = 0; m_p2 = 0; m_p3 = 0;
    endtask

    task automatic model_step();
        logic [31:0] setv, clrv;
        if (rst) begin
            model_reset();
        end else begin
            setv = place(src_evt);
            setv[26] = m_p2 & ~m_p3;
            setv = setv & m_len;
            clrv = (bus_wen && bus_addr == 8'h04) ? bus_wdata : 32'h0;
            m_sticky = (m_sticky & ~clrv) | setv;
            if (bus_wen && bus_addr == 8'h08) m_len = bus_wdata;
            if (bus_wen && bus_addr == 8'h0C) m_sen = bus_wdata;
            m_p3 = m_p2; m_p2 = m_p1; m_p1 = rdy_pin;
        end
    endtask

    // Called at a negedge with inputs already driven.
    task automatic tick(input string tag);
        #1;
        check({tag, " rdata"}, bus_rdata, exp_read(bus_addr));
        check({tag, " irq"}, {31'b0, irq}, {31'b0, |(view() & m_sen)});
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        bus_wen = 0; src_evt = '0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        bus_wen = 1; bus_addr = a; bus_wdata = d;
        tick(tag);
        bus_wen = 0;
    endtask

    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_wen = 0; bus_addr = a; #1; d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge clk);
        repeat (3) tick("R1 in-reset");
        rst = 0;

        // R1: state after reset
        peek(8'h04, d); check("R1 status", d, 32'h0);
        peek(8'h08, d); check("R1 latch mask", d, 32'h0);
        peek(8'h0C, d); check("R1 signal mask", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        tick("R1");

        // R2: mask readback and unmapped addresses
        wr(8'h08, 32'hFFFF_FFFF, "R2");
        wr(8'h0C, 32'hA5A5_0000, "R2");
        peek(8'h08, d); check("R2 latch readback", d, 32'hFFFF_FFFF);
        peek(8'h0C, d); check("R2 signal readback", d, 32'hA5A5_0000);
        peek(8'h10, d); check("R2 unmapped 0x10", d, 32'h0);
        peek(8'h00, d); check("R2 unmapped 0x00", d, 32'h0);
        wr(8'h0C, 32'h0, "R2");

        // R3: ECC source k5 -> bit 17
        src_evt = 8'h20; tick("R3"); idle();
        peek(8'h04, d); check("R3 ecc bit17", d & 32'h0002_0000, 32'h0002_0000);
        // R8: latched but not signalled
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h0002_0000, "R8");
        check("R8 irq raised", {31'b0, irq}, 32'h1);

        // R4: writing 0 keeps, writing 1 clears
        wr(8'h04, 32'h0, "R4");
        peek(8'h04, d); check("R4 keep", d & 32'h0002_0000, 32'h0002_0000);
        wr(8'h04, 32'h0002_0000, "R4");
        peek(8'h04, d); check("R4 cleared", d & 32'h0002_0000, 32'h0);
        check("R8 irq dropped", {31'b0, irq}, 32'h0);

        // R3: latch mask off for CRC (bit 16)
        wr(8'h08, ~32'h0001_0000, "R3");
        src_evt = 8'h10; tick("R3"); idle();
        peek(8'h04, d); check("R3 gated crc", d & 32'h0001_0000, 32'h0);

        // R5: event and clear collide on bit 17
        src_evt = 8'h20; bus_wen = 1; bus_addr = 8'h04; bus_wdata = 32'h0002_0000;
        tick("R5"); idle();
        peek(8'h04, d); check("R5 event wins", d & 32'h0002_0000, 32'h0002_0000);

        // R9: latch mask cleared under a set bit
        wr(8'h08, 32'h0, "R9");
        peek(8'h04, d); check("R9 kept", d & 32'h0002_0000, 32'h0002_0000);
        wr(8'h04, 32'hFFFF_FFFF, "R9");
        wr(8'h08, 32'hFFFF_FFFF, "R9");

        // R6: ready pin sync latency and single set
        rdy_pin = 1;
        tick("R6"); tick("R6");
        peek(8'h04, d); check("R6 not yet", d & 32'h0400_0000, 32'h0);
        tick("R6");
        peek(8'h04, d); check("R6 set on 3rd edge", d & 32'h0400_0000, 32'h0400_0000);
        wr(8'h04, 32'h0400_0000, "R6");
        repeat (5) tick("R6 held");
        peek(8'h04, d); check("R6 no reset while held", d & 32'h0400_0000, 32'h0);
        rdy_pin = 0; repeat (3) tick("R6");
        rdy_pin = 1; repeat (4) tick("R6");
        peek(8'h04, d); check("R6 second edge", d & 32'h0400_0000, 32'h0400_0000);
        wr(8'h04, 32'hFFFF_FFFF, "R6");

        // R7: live FIFO bits
        fifo_lvl = 4'hF;
        peek(8'h04, d); check("R7 live", d & 32'hF, 32'hF);
        wr(8'h04, 32'h0000_000F, "R7");
        peek(8'h04, d); check("R7 write ignored", d & 32'hF, 32'hF);
        wr(8'h08, 32'hFFFF_FFF0, "R7");
        peek(8'h04, d); check("R7 masked", d & 32'hF, 32'h0);
        wr(8'h08, 32'hFFFF_FFFF, "R7");
        fifo_lvl = 4'h5;
        peek(8'h04, d); check("R7 follows level", d & 32'hF, 32'h5);

        // R10: everything active, undefined bits stay 0
        src_evt = 8'hFF; tick("R10"); idle();
        peek(8'h04, d); check("R10 undefined zero", d & 32'hF8FC_E1F0, 32'h0);
        check("R3 all sources", d & 32'h0303_1E00, 32'h0303_1E00);

        // Random phase: R3 R4 R5 R6 R7 R8 R9 against the bench model
        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r;
            logic [7:0] addrs [5] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10};
            r = int'($urandom_range(0, 99));
            bus_addr = addrs[$urandom_range(0, 4)];
            bus_wen = (r < 30);
            if (bus_addr == 8'h08 || bus_addr == 8'h0C) bus_wen = (r < 4);
            bus_wdata = $urandom();
            src_evt = ($urandom_range(0, 3) == 0) ? 8'($urandom()) : 8'h0;
            if ($urandom_range(0, 15) == 0) fifo_lvl = 4'($urandom());
            if ($urandom_range(0, 9) == 0) rdy_pin = ~rdy_pin;
            tick("R3 R4 R5 R6 R7 R8 R9 random");
        end
        idle();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule